// File: doc/BRIEF.md
# Packet-Command PIO Read Sequencer

This block is the device-side control for a packet command that moves read data to the host by programmed I/O. The host loads a byte-count limit into two byte registers and writes the packet command code. The block asks for a 12-byte command packet, which arrives as six 16-bit writes. If that packet is a read-blocks request, the block streams the requested 2048-byte blocks out through the 16-bit data register. It splits the transfer into bursts that never exceed the host's limit.

Each burst is announced with an interrupt and a data-request status. Between bursts the block holds a busy status for a few cycles. A separate interrupt marks the end of the whole command. The block fetches data words from a combinational word-read source addressed in 16-bit words. Any other packet opcode, or a request for DMA, ends the command with an error status.

Top module: `atapi_pio_engine`

## Requirements
- R1: After reset the status reads 0x40 (ready only), `irq` is low, and a read of the data register (address 0) returns 0.
- R2: Writing 0xA0 to the command register (address 7) while idle, with feature bit 0 (address 1) clear, latches the limit. The limit's low byte comes from address 4 and its high byte from address 5. The status then reads 0xC0 (busy and ready) for `BSY_CYCLES` cycles. After that it reads 0x48 (data request and ready), and no interrupt is raised.
- R3: The packet is six writes to address 0, and write k carries packet byte 2k in its low byte. Byte 0 must be 0x28. Bytes 2 to 5 give the block address, most significant byte first. Bytes 7 and 8 give the block count, most significant byte first. The first source word address is block address × 1024.
- R4: An odd limit is rounded down to even. A limit of 0 or 1 is taken as 0xFFFE. Each burst moves the lesser of the effective limit and the bytes remaining. During a burst, that burst's byte count reads back at address 4 (low byte) and address 5 (high byte).
- R5: At the start of every burst, `irq` rises and the status reads 0x48.
- R6: Each data-register read during a burst returns the source word at the current address and then advances the address by one. After the last word of a burst that is not the final one, the status reads 0xC0.
- R7: After the final word, `irq` rises and the status reads 0x40. A packet with a block count of zero completes in the same way without any data phase.
- R8: Reading the status register (address 7) clears `irq`. Reading the alternate status (address 2) returns the same value and leaves `irq` unchanged.
- R9: A 0xA0 command issued with feature bit 0 set is rejected, and so is a packet whose opcode is not 0x28. In either case the status becomes 0x41 (error and ready) and `irq` rises, with no data phase. The error bit is cleared by the next accepted 0xA0 command.
- R10: Command codes other than 0xA0 are ignored: the status stays 0x40 and `irq` stays low.
- R11: The busy and data-request status bits are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Interrupt request, level |
| src_addr | output | SRC_AW | Word address into the block source |
| src_rdata | input | 16 | Source word at `src_addr` |

## Verification
If the word-remaining counter or the burst counter goes wrong, the error shows up within a single burst. The burst size read back at addresses 4 and 5 will be wrong, or the interrupt and busy status will arrive at the wrong word, or data will be read past the expected end. A wrong source address shows up as a data mismatch on the very first word of a burst. The interrupt flag is observed directly at its pin around every status and alternate-status read. A clearing or set-priority fault is therefore seen on the next cycle.

// File: rtl/atapi_pio_engine.sv
module atapi_pio_engine #(
  parameter int BSY_CYCLES = 3,
  parameter int SRC_AW     = 32,
  parameter int BLK_BYTES  = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              irq,
  output logic [SRC_AW-1:0] src_addr,
  input  logic [15:0]       src_rdata
);

  localparam int BLK_WORDS = BLK_BYTES / 2;
  localparam int BLK_SH    = $clog2(BLK_WORDS);
  localparam int REM_W     = 16 + BLK_SH;
  localparam int CW        = $clog2(BSY_CYCLES + 1);

  localparam logic [2:0] A_DATA = 3'd0, A_FEAT = 3'd1, A_ALT = 3'd2,
                         A_LIML = 3'd4, A_LIMH = 3'd5, A_CMD = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_BUSY, S_PKT, S_DEC, S_PREP, S_DATA} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic             feat_dma;
  logic [6:0]       lim_lo;
  logic [7:0]       lim_hi;
  logic [14:0]      eff_words;
  logic [2:0]       widx;
  logic [7:0]       op_q;
  logic [31:0]      lba_q;
  logic [15:0]      nblk_q;
  logic [REM_W-1:0] remain;
  logic [14:0]      burst_left, burst_len;
  logic [SRC_AW-1:0] addr_q;
  logic             err_q, irq_q;

  wire [14:0] lim_words = {lim_hi, lim_lo};
  wire        wr_cmd    = reg_wr && reg_addr == A_CMD;
  wire        go_pkt    = st == S_IDLE && wr_cmd && reg_wdata[7:0] == 8'hA0 && !feat_dma;
  wire        dma_rej   = st == S_IDLE && wr_cmd && reg_wdata[7:0] == 8'hA0 && feat_dma;
  wire        wr_data   = reg_wr && reg_addr == A_DATA && st == S_PKT;
  wire        rd_data   = reg_rd && reg_addr == A_DATA && st == S_DATA;
  wire        dec_bad   = st == S_DEC && op_q != 8'h28;
  wire        dec_empty = st == S_DEC && op_q == 8'h28 && nblk_q == 16'd0;
  wire        prep_done = st == S_PREP && cnt == '0;
  wire        last_word = rd_data && burst_left == 15'd1;
  wire        all_done  = last_word && remain == REM_W'(1);
  wire        irq_set   = dma_rej | dec_bad | dec_empty | prep_done | all_done;
  wire        irq_clr   = (reg_rd && reg_addr == A_CMD) | wr_cmd;

  wire [14:0] next_burst = ({{(REM_W-15){1'b0}}, eff_words} < remain) ? eff_words : remain[14:0];

  wire bsy = st == S_BUSY || st == S_DEC || st == S_PREP;
  wire drq = st == S_PKT || st == S_DATA;
  wire [7:0] status = {bsy, 1'b1, 1'b0, 1'b0, drq, 1'b0, 1'b0, err_q};

  assign irq      = irq_q;
  assign src_addr = addr_q;

  always_comb begin
    case (reg_addr)
      A_DATA:        reg_rdata = (st == S_DATA) ? src_rdata : 16'h0000;
      A_ALT, A_CMD:  reg_rdata = {8'h00, status};
      A_LIML:        reg_rdata = {8'h00, burst_len[6:0], 1'b0};
      A_LIMH:        reg_rdata = {8'h00, burst_len[14:7]};
      default:       reg_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat_dma <= 1'b0;
      lim_lo   <= '0;
      lim_hi   <= '0;
    end else if (reg_wr && st == S_IDLE) begin
      if (reg_addr == A_FEAT) feat_dma <= reg_wdata[0];
      if (reg_addr == A_LIML) lim_lo   <= reg_wdata[7:1];
      if (reg_addr == A_LIMH) lim_hi   <= reg_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (irq_set) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= '0;
      lba_q  <= '0;
      nblk_q <= '0;
    end else if (wr_data) begin
      case (widx)
        3'd0: op_q          <= reg_wdata[7:0];
        3'd1: lba_q[31:16]  <= {reg_wdata[7:0], reg_wdata[15:8]};
        3'd2: lba_q[15:0]   <= {reg_wdata[7:0], reg_wdata[15:8]};
        3'd3: nblk_q[15:8]  <= reg_wdata[15:8];
        3'd4: nblk_q[7:0]   <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      widx       <= '0;
      eff_words  <= '0;
      remain     <= '0;
      burst_left <= '0;
      burst_len  <= '0;
      addr_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (go_pkt) begin
            st        <= S_BUSY;
            cnt       <= CW'(BSY_CYCLES - 1);
            err_q     <= 1'b0;
            eff_words <= (lim_words == 15'd0) ? 15'h7FFF : lim_words;
          end else if (dma_rej) begin
            err_q <= 1'b1;
          end
        end
        S_BUSY: begin
          if (cnt == '0) begin
            st   <= S_PKT;
            widx <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PKT: begin
          if (wr_data) begin
            widx <= widx + 3'd1;
            if (widx == 3'd5) st <= S_DEC;
          end
        end
        S_DEC: begin
          if (dec_bad) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (dec_empty) begin
            st <= S_IDLE;
          end else begin
            remain <= REM_W'(nblk_q) << BLK_SH;
            addr_q <= SRC_AW'({lba_q, {BLK_SH{1'b0}}});
            cnt    <= CW'(BSY_CYCLES - 1);
            st     <= S_PREP;
          end
        end
        S_PREP: begin
          if (prep_done) begin
            burst_left <= next_burst;
            burst_len  <= next_burst;
            st         <= S_DATA;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_DATA: begin
          if (rd_data) begin
            addr_q     <= addr_q + 1'b1;
            remain     <= remain - 1'b1;
            burst_left <= burst_left - 1'b1;
            if (last_word) begin
              st  <= all_done ? S_IDLE : S_PREP;
              cnt <= CW'(BSY_CYCLES - 1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_bsy_drq_excl: assert property (@(posedge clk) disable iff (!rst_n) !(bsy && drq));

  a_r8_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CMD && !irq_set) |=> !irq);

  a_r8_alt_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_ALT && irq && !wr_cmd) |=> irq);

  a_r4_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (burst_left != 15'd0 && {{(REM_W-15){1'b0}}, burst_left} <= remain
                        && burst_left <= eff_words));

  a_r7_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_DATA && st == S_IDLE) |-> irq);

  a_r5_burst_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_PREP && st == S_DATA) |-> irq);

  a_r2_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    go_pkt |=> (bsy && !irq));

endmodule

// File: tb/atapi_pio_engine_tb.sv
module atapi_pio_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        irq;
  logic [31:0] src_addr;
  logic [15:0] src_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[15:0] ^ {a[7:0], a[23:16]} ^ 16'h3C5A;
  endfunction

  assign src_rdata = mem_word(src_addr);

  atapi_pio_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .src_addr(src_addr), .src_rdata(src_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 200) begin @(negedge clk); n++; end
    chk(irq === 1'b1, req, irq, 1);
  endtask

  task automatic start_cmd(input logic [15:0] lim);
    logic [15:0] s;
    int n = 0;
    wr(3'd1, 16'h0000);
    wr(3'd4, {8'h00, lim[7:0]});
    wr(3'd5, {8'h00, lim[15:8]});
    wr(3'd7, 16'h00A0);
    rd(3'd2, s);
    chk(s == 16'h00C0, "R2 busy after command", s, 16'hC0);
    while (s[7] && n < 50) begin rd(3'd2, s); n++; end
    chk(s == 16'h0048, "R2 packet request status (R9 err cleared)", s, 16'h48);
    chk(irq == 1'b0, "R2 no irq for packet request", irq, 0);
  endtask

  task automatic send_pkt(input logic [7:0] op, input logic [31:0] lba, input logic [15:0] nblk);
    wr(3'd0, {8'h00, op});
    wr(3'd0, {lba[23:16], lba[31:24]});
    wr(3'd0, {lba[7:0], lba[15:8]});
    wr(3'd0, {nblk[15:8], 8'h00});
    wr(3'd0, {8'h00, nblk[7:0]});
    wr(3'd0, 16'h0000);
  endtask

  task automatic finish_check();
    logic [15:0] s;
    wait_irq("R7 completion irq");
    rd(3'd2, s);
    chk(s == 16'h0040, "R8 alt status at completion", s, 16'h40);
    chk(irq == 1'b1, "R8 alt read keeps irq", irq, 1);
    rd(3'd7, s);
    chk(s == 16'h0040, "R7 completion status", s, 16'h40);
    chk(irq == 1'b0, "R8 status read clears irq", irq, 0);
  endtask

  task automatic run_read(input logic [15:0] lim, input logic [31:0] lba, input logic [15:0] nblk);
    logic [15:0] s, lo, hi;
    int eff, rem, nb, bad, exp_bursts, bursts;
    logic [31:0] a;
    eff = lim & 16'hFFFE;
    if (eff == 0) eff = 16'hFFFE;
    rem = int'(nblk) * 2048;
    a = lba * 1024;
    exp_bursts = (rem + eff - 1) / eff;
    bursts = 0;
    start_cmd(lim);
    send_pkt(8'h28, lba, nblk);
    while (rem > 0) begin
      wait_irq("R5 burst irq");
      rd(3'd7, s);
      chk(s == 16'h0048, "R5 burst status", s, 16'h48);
      chk(irq == 1'b0, "R8 status read clears burst irq", irq, 0);
      nb = (eff < rem) ? eff : rem;
      rd(3'd4, lo);
      rd(3'd5, hi);
      chk({hi[7:0], lo[7:0]} == nb[15:0], "R4 burst byte count", {hi[7:0], lo[7:0]}, nb);
      bad = 0;
      for (int i = 0; i < nb / 2; i++) begin
        rd(3'd0, s);
        if (s !== mem_word(a)) bad++;
        a++;
      end
      chk(bad == 0, "R3 R6 burst data words", bad, 0);
      rem -= nb;
      bursts++;
      if (rem > 0) begin
        rd(3'd2, s);
        chk(s == 16'h00C0, "R6 busy between bursts", s, 16'hC0);
      end
    end
    chk(bursts == exp_bursts, "R4 burst count", bursts, exp_bursts);
    finish_check();
  endtask

  task automatic t_reset();
    logic [15:0] s;
    rd(3'd7, s);
    chk(s == 16'h0040, "R1 reset status", s, 16'h40);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);
    rd(3'd0, s);
    chk(s == 16'h0000, "R1 idle data read", s, 0);
  endtask

  task automatic t_ignored_cmd();
    logic [15:0] s;
    wr(3'd7, 16'h00EC);
    rd(3'd2, s);
    chk(s == 16'h0040, "R10 other command ignored", s, 16'h40);
    chk(irq == 1'b0, "R10 no irq for other command", irq, 0);
  endtask

  task automatic t_dma_reject();
    logic [15:0] s;
    wr(3'd1, 16'h0001);
    wr(3'd7, 16'h00A0);
    chk(irq == 1'b1, "R9 DMA request irq", irq, 1);
    rd(3'd7, s);
    chk(s == 16'h0041, "R9 DMA request error status", s, 16'h41);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_bad_opcode();
    logic [15:0] s;
    start_cmd(16'd5120);
    send_pkt(8'h12, 32'd0, 16'd1);
    wait_irq("R9 bad opcode irq");
    rd(3'd7, s);
    chk(s == 16'h0041, "R9 bad opcode error status", s, 16'h41);
  endtask

  task automatic t_zero_count();
    start_cmd(16'd5120);
    send_pkt(8'h28, 32'd7, 16'd0);
    finish_check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignored_cmd();
    t_dma_reject();
    run_read(16'd5120, 32'd0, 16'd1);
    run_read(16'd5121, 32'd3, 16'd3);
    t_bad_opcode();
    run_read(16'd5120, 32'h0001_0002, 16'd5);
    t_zero_count();
    run_read(16'd0, 32'd40, 16'd33);
    run_read(16'd1, 32'd9, 16'd1);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
    if (!done) chk(1'b0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule